// File: doc/BRIEF.md
# Flash Row-Write Sequencer

This controller gathers one program-memory row in a bank of byte-wide holding registers and then programs the whole row in one timed operation. The CPU first loads a byte into a data latch. A table-write strobe then copies that byte into the holding register chosen by the low pointer bits. The strobe can also step the pointer forward by one. These short writes never reach the flash.

A long write needs three things, in this order. The write-enable bit must be set. The unlock register must receive 55h and then AAh. Then the start bit is written. The row number is taken from the upper pointer bits at the moment of the start write. The block then gives a one-cycle program strobe to the array, together with the row address and the 512-bit payload. It holds the CPU stalled until an internal cycle counter expires.

A start request without valid preconditions is dropped and raises an error flag. Each start attempt uses up the unlock state. The holding registers are never cleared, so bytes that are not rewritten carry over into the next row write.

Top module: `flash_row_sequencer`

## Requirements
- R1: A table write while idle copies the data latch into holding byte `ptr_o[5:0]` and causes no program strobe.
- R2: A table write with `tblinc_i` high adds one to the pointer, wrapping from all-ones to zero. With `tblinc_i` low, the pointer is unchanged.
- R3: A start write (control bit 1 set) commits only if three conditions hold: write-enable (control bit 0) was already set, and the two most recent unlock-register writes were 55h then AAh. A commit gives `prog_o` for exactly one cycle, with `row_addr_o` equal to `ptr_o[PTR_W-1:6]` at the time of the start write.
- R4: Any other unlock history makes the start request do nothing (no `prog_o`) and sets the error flag (control bit 2). This includes a non-key byte between 55h and AAh, or AAh alone.
- R5: A start request made while write-enable is clear does nothing and sets the error flag.
- R6: After a commit, `stall_o` stays high for exactly `PROG_CYCLES` cycles, and control bit 1 reads as 1 during that time.
- R7: `done_o` pulses for one cycle in the cycle where `stall_o` first reads low again, and control bit 1 reads 0 from then on.
- R8: Every start attempt uses up the unlock state, so a second start with no new 55h/AAh pair fails.
- R9: The holding registers keep their contents across commits. A later commit sends the old bytes unless they have been overwritten.
- R10: While stalled, pointer loads, table writes and register writes have no effect.
- R11: After reset, the pointer, data latch, control bits and holding registers are zero, and `stall_o`, `prog_o` and `done_o` are low.
- R12: A control write with bit 2 clear clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 data latch, 1 control, 2 unlock |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register (unlock reads 0) |
| ptr_we_i | input | 1 | Pointer load strobe |
| ptr_wdata_i | input | PTR_W | Pointer load value |
| ptr_o | output | PTR_W | Table pointer |
| tblwt_i | input | 1 | Table write strobe |
| tblinc_i | input | 1 | Increment pointer with this table write |
| stall_o | output | 1 | CPU stall, high during the long write |
| prog_o | output | 1 | One-cycle program strobe to the array |
| row_addr_o | output | PTR_W-6 | Row being programmed |
| row_data_o | output | ROW_BYTES*8 | Holding-register payload, byte i at bits 8i+7:8i |
| done_o | output | 1 | One-cycle pulse when the long write ends |

## Verification
The bench sweeps every pair of unlock bytes drawn from {55h, AAh, 00h, 5Ah}, with write-enable both set and clear. This exposes a tracker that accepts AAh alone, accepts the keys in reversed order, or ignores write-enable. It fills whole rows at the first, a middle and the last row index. It also starts a commit with the pointer left one row ahead after 64 increments, which catches a design that latches the row at the wrong moment. It repeats a start without a new unlock pair to catch an unlock that is never used up. It rewrites a single byte and checks that the other bytes carry over, which catches a buffer that clears itself. Stall length and done timing are counted to the cycle. Writes issued during a stall must leave the pointer, latch and payload untouched.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_UNLOCK = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_st_e;

  localparam int unsigned CTRL_WREN = 0;
  localparam int unsigned CTRL_WR   = 1;
  localparam int unsigned CTRL_ERR  = 2;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/frs_unlock.sv
module frs_unlock
  import frs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       consume_i,
  output logic       armed_o
);
  unlock_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= UL_IDLE;
    end else if (consume_i) begin
      st_q <= UL_IDLE;
    end else if (wr_i) begin
      if (data_i == KEY_FIRST)                          st_q <= UL_HALF;
      else if (data_i == KEY_SECOND && st_q == UL_HALF) st_q <= UL_ARMED;
      else                                              st_q <= UL_IDLE;
    end
  end

  assign armed_o = (st_q == UL_ARMED);
endmodule

// File: rtl/frs_hold_buf.sv
module frs_hold_buf #(
  parameter int unsigned ROW_BYTES = 64,
  localparam int unsigned IDX_W    = $clog2(ROW_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             data_i,
  output logic [ROW_BYTES*8-1:0] row_o
);
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                b_q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))        b_q <= data_i;
    end
    assign row_o[g*8 +: 8] = b_q;
  end
endmodule

// File: rtl/frs_prog_timer.sv
module frs_prog_timer #(
  parameter int unsigned PROG_CYCLES = 100000,
  localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_row_sequencer.sv
module flash_row_sequencer
  import frs_pkg::*;
#(
  parameter int unsigned PTR_W       = 21,
  parameter int unsigned ROW_BYTES   = 64,
  parameter int unsigned PROG_CYCLES = 100000,
  localparam int unsigned IDX_W      = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W      = PTR_W - IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_sel_i,
  input  logic [7:0]             reg_wdata_i,
  output logic [7:0]             reg_rdata_o,
  input  logic                   ptr_we_i,
  input  logic [PTR_W-1:0]       ptr_wdata_i,
  output logic [PTR_W-1:0]       ptr_o,
  input  logic                   tblwt_i,
  input  logic                   tblinc_i,
  output logic                   stall_o,
  output logic                   prog_o,
  output logic [ROW_W-1:0]       row_addr_o,
  output logic [ROW_BYTES*8-1:0] row_data_o,
  output logic                   done_o
);
  logic       busy, armed;
  logic       cpu_ok, data_wr, ctrl_wr, unlock_wr, start_req, start_ok;
  logic [7:0] latch_q;
  logic       wren_q, err_q;

  assign cpu_ok    = !busy;
  assign data_wr   = cpu_ok && reg_we_i && (reg_sel_i == SEL_DATA);
  assign ctrl_wr   = cpu_ok && reg_we_i && (reg_sel_i == SEL_CTRL);
  assign unlock_wr = cpu_ok && reg_we_i && (reg_sel_i == SEL_UNLOCK);
  assign start_req = ctrl_wr && reg_wdata_i[CTRL_WR];
  // enable must come from an earlier control write
  assign start_ok  = start_req && wren_q && armed;

  frs_unlock i_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (unlock_wr),
    .data_i    (reg_wdata_i),
    .consume_i (start_req),
    .armed_o   (armed)
  );

  frs_hold_buf #(.ROW_BYTES(ROW_BYTES)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cpu_ok && tblwt_i),
    .idx_i  (ptr_o[IDX_W-1:0]),
    .data_i (latch_q),
    .row_o  (row_data_o)
  );

  frs_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= '0;
      wren_q     <= 1'b0;
      err_q      <= 1'b0;
      ptr_o      <= '0;
      prog_o     <= 1'b0;
      row_addr_o <= '0;
    end else begin
      prog_o <= start_ok;
      if (data_wr) latch_q <= reg_wdata_i;
      if (ctrl_wr) wren_q <= reg_wdata_i[CTRL_WREN];
      if (start_req && !start_ok) err_q <= 1'b1;
      else if (ctrl_wr)           err_q <= err_q & reg_wdata_i[CTRL_ERR];
      if (start_ok) row_addr_o <= ptr_o[PTR_W-1:IDX_W];
      if (cpu_ok) begin
        if (ptr_we_i)               ptr_o <= ptr_wdata_i;
        else if (tblwt_i && tblinc_i) ptr_o <= ptr_o + 1'b1;
      end
    end
  end

  assign stall_o = busy;

  always_comb begin
    unique case (reg_sel_i)
      SEL_DATA: reg_rdata_o = latch_q;
      SEL_CTRL: begin
        reg_rdata_o            = '0;
        reg_rdata_o[CTRL_WREN] = wren_q;
        reg_rdata_o[CTRL_WR]   = busy;
        reg_rdata_o[CTRL_ERR]  = err_q;
      end
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/frs_checker.sv
module frs_checker
  import frs_pkg::*;
#(
  parameter int unsigned PTR_W       = 21,
  parameter int unsigned ROW_BYTES   = 64,
  parameter int unsigned PROG_CYCLES = 100000,
  localparam int unsigned IDX_W      = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W      = PTR_W - IDX_W,
  localparam int unsigned SC_W       = $clog2(PROG_CYCLES + 2)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_we_i,
  input logic [1:0]             reg_sel_i,
  input logic [7:0]             reg_wdata_i,
  input logic [PTR_W-1:0]       ptr_o,
  input logic                   stall_o,
  input logic                   prog_o,
  input logic [ROW_W-1:0]       row_addr_o,
  input logic [ROW_BYTES*8-1:0] row_data_o,
  input logic                   done_o
);
  logic [SC_W-1:0] stall_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stall_cnt_q <= '0;
    else if (stall_o) stall_cnt_q <= stall_cnt_q + 1'b1;
    else              stall_cnt_q <= '0;
  end

  AST_PROG_STARTS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> stall_o && !$past(stall_o)); // R3
  AST_STALL_HAS_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> prog_o); // R3
  AST_PROG_FROM_START_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> $past(reg_we_i && reg_sel_i == SEL_CTRL && reg_wdata_i[CTRL_WR])); // R3
  AST_PROG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> !prog_o); // R3
  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_cnt_q <= SC_W'(PROG_CYCLES)); // R6
  AST_DONE_AFTER_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stall_o && $past(stall_o) && stall_cnt_q == SC_W'(PROG_CYCLES)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && $past(stall_o) |-> $stable(ptr_o)); // R10
  AST_PAYLOAD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && $past(stall_o) |-> $stable(row_data_o)); // R10
  AST_ROW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && $past(stall_o) |-> $stable(row_addr_o)); // R3
endmodule

bind flash_row_sequencer frs_checker #(
  .PTR_W(PTR_W), .ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)
) i_frs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .ptr_o       (ptr_o),
  .stall_o     (stall_o),
  .prog_o      (prog_o),
  .row_addr_o  (row_addr_o),
  .row_data_o  (row_data_o),
  .done_o      (done_o)
);

// File: tb/test_flash_row_sequencer.sv
module test_flash_row_sequencer;
  localparam int PTR_W = 12;
  localparam int RB    = 64;
  localparam int PC    = 12;
  localparam int ROW_W = PTR_W - 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ptr_we = 1'b0;
  logic [PTR_W-1:0] ptr_wdata = '0;
  logic [PTR_W-1:0] ptr;
  logic tblwt = 1'b0, tblinc = 1'b0;
  logic stall, prog, done;
  logic [ROW_W-1:0] row_addr;
  logic [RB*8-1:0] row_data;

  int n_chk = 0, n_fail = 0, prog_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_hold [RB];
  logic [RB*8-1:0] cap_data;
  logic [ROW_W-1:0] cap_addr;

  always #10 clk = ~clk;

  flash_row_sequencer #(.PTR_W(PTR_W), .ROW_BYTES(RB), .PROG_CYCLES(PC)) i_flash_row_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ptr_we_i(ptr_we),
    .ptr_wdata_i(ptr_wdata), .ptr_o(ptr), .tblwt_i(tblwt), .tblinc_i(tblinc),
    .stall_o(stall), .prog_o(prog), .row_addr_o(row_addr), .row_data_o(row_data),
    .done_o(done)
  );

  always @(posedge clk) if (prog === 1'b1) prog_cnt++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic load_ptr(input logic [PTR_W-1:0] v);
    @(negedge clk); ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_we = 1'b0;
  endtask

  task automatic tbl_write(input logic [7:0] b, input bit inc);
    wr_reg(2'd0, b);
    exp_hold[ptr[5:0]] = b;
    tblwt = 1'b1; tblinc = inc;
    @(negedge clk); tblwt = 1'b0; tblinc = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] a, input logic [7:0] b);
    wr_reg(2'd2, a);
    wr_reg(2'd2, b);
  endtask

  // start write; on success wait out the stall and capture the payload
  task automatic commit(input bit w, input bit exp_ok, input string tag);
    logic [7:0] r;
    int n;
    wr_reg(2'd1, {6'b0, 1'b1, w});
    chk(prog == exp_ok, {tag, " prog strobe"}, prog, exp_ok);
    rd_reg(2'd1, r);
    chk(r[2] == !exp_ok, {tag, " error flag"}, r[2], !exp_ok);
    if (exp_ok) begin
      cap_addr = row_addr;
      cap_data = row_data;
      chk(r[1] == 1'b1, "R6 start bit reads 1 while busy", r[1], 1);
      n = 0;
      while (stall === 1'b1 && n < 4 * PC) begin
        n++;
        @(negedge clk);
      end
      chk(n == PC, "R6 stall length", n, PC);
      chk(done == 1'b1, "R7 done with stall release", done, 1);
      rd_reg(2'd1, r);
      chk(r[1] == 1'b0, "R7 start bit clears", r[1], 0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
    end
  endtask

  function automatic bit payload_ok();
    for (int i = 0; i < RB; i++)
      if (cap_data[i*8 +: 8] !== exp_hold[i]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] keys [4] = '{8'h55, 8'hAA, 8'h00, 8'h5A};
    int rows [3] = '{0, 5, 63};
    for (int i = 0; i < RB; i++) exp_hold[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(ptr == 0, "R11 pointer", ptr, 0);
    chk(!stall && !prog && !done, "R11 outputs low", {stall, prog, done}, 0);
    rd_reg(2'd1, r); chk(r == 0, "R11 control", r, 0);
    rd_reg(2'd0, r); chk(r == 0, "R11 latch", r, 0);
    chk(row_data == '0, "R11 holding registers", row_data[63:0], 0);

    // R1/R3 full-row fills at first, middle and last rows
    wr_reg(2'd1, 8'h01);
    foreach (rows[k]) begin
      load_ptr(PTR_W'(rows[k] * 64));
      for (int i = 0; i < RB; i++) tbl_write(8'((rows[k] * 37 + i * 11 + 5) & 8'hFF), 1'b1);
      chk(prog_cnt == k, "R1 table writes do not program", prog_cnt, k);
      load_ptr(PTR_W'(rows[k] * 64));
      unlock(8'h55, 8'hAA);
      commit(1'b1, 1'b1, "R3 row fill");
      chk(cap_addr == ROW_W'(rows[k]), "R3 row address", cap_addr, rows[k]);
      chk(payload_ok(), "R1 row payload", cap_data[63:0], {exp_hold[7], exp_hold[6], exp_hold[5],
          exp_hold[4], exp_hold[3], exp_hold[2], exp_hold[1], exp_hold[0]});
    end

    // R3 pointer left one row ahead after 64 increments
    load_ptr(PTR_W'(2 * 64));
    for (int i = 0; i < RB; i++) tbl_write(8'(i ^ 8'hA5), 1'b1);
    chk(ptr == PTR_W'(3 * 64), "R2 pointer after 64 increments", ptr, 3 * 64);
    unlock(8'h55, 8'hAA);
    commit(1'b1, 1'b1, "R3 row from current pointer");
    chk(cap_addr == ROW_W'(3), "R3 row taken at start", cap_addr, 3);

    // R2 increment control and wrap
    load_ptr(12'h105);
    tbl_write(8'h11, 1'b0);
    chk(ptr == 12'h105, "R2 no increment", ptr, 12'h105);
    tbl_write(8'h22, 1'b1);
    chk(ptr == 12'h106, "R2 increment", ptr, 12'h106);
    load_ptr(12'hFFF);
    tbl_write(8'h33, 1'b1);
    chk(ptr == 12'h000, "R2 wrap", ptr, 0);

    // R3/R4/R5 unlock sweep
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          wr_reg(2'd1, {7'b0, 1'(w)});
          unlock(keys[a], keys[b]);
          commit(1'(w), (w == 1) && (a == 0) && (b == 1),
                 w == 0 ? "R5 sweep" : "R4 sweep");
        end

    // R4 interleaved byte breaks the sequence; R3 repeated first key still valid
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd2, 8'h55); wr_reg(2'd2, 8'h00); wr_reg(2'd2, 8'hAA);
    commit(1'b1, 1'b0, "R4 interleaved byte");
    wr_reg(2'd2, 8'h55); wr_reg(2'd2, 8'h55); wr_reg(2'd2, 8'hAA);
    commit(1'b1, 1'b1, "R3 repeated first key");

    // R8 unlock consumed
    commit(1'b1, 1'b0, "R8 second start without unlock");
    // R12 error clear
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, r);
    chk(r[2] == 1'b0, "R12 error cleared", r[2], 0);

    // R9 holding registers retained, single byte rewritten
    load_ptr(PTR_W'(5 * 64 + 3));
    tbl_write(8'hC3, 1'b0);
    unlock(8'h55, 8'hAA);
    commit(1'b1, 1'b1, "R9 partial rewrite");
    chk(payload_ok(), "R9 retained payload", cap_data[63:0], {exp_hold[7], exp_hold[6],
        exp_hold[5], exp_hold[4], exp_hold[3], exp_hold[2], exp_hold[1], exp_hold[0]});

    // R10 writes during stall ignored
    wr_reg(2'd0, 8'h5E);
    unlock(8'h55, 8'hAA);
    @(negedge clk); reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h03;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = 12'hABC; tblwt = 1'b1; tblinc = 1'b1;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h77;
    @(negedge clk);
    ptr_we = 1'b0; tblwt = 1'b0; tblinc = 1'b0; reg_we = 1'b0;
    chk(stall == 1'b1, "R10 stall active during test writes", stall, 1);
    while (stall === 1'b1) @(negedge clk);
    chk(ptr == PTR_W'(5 * 64 + 3), "R10 pointer untouched", ptr, 5 * 64 + 3);
    rd_reg(2'd0, r);
    chk(r == 8'h5E, "R10 latch untouched", r, 8'h5E);
    cap_data = row_data;
    chk(payload_ok(), "R10 holding registers untouched", cap_data[63:0], 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule